// File: doc/BRIEF.md
# Dual-Clock High-Resolution Event Timestamper

This block stamps an asynchronous event, such as the rising edge of a radio frame-delimiter line, with a time value whose resolution is one period of a fast clock. The time base, though, rests on a wide counter of slow-clock ticks that can run for very long intervals. The whole block runs on the fast clock. The slow clock reaches it as a one-cycle enable, `slow_tick`, that has already been synchronised. A phase counter counts fast cycles and restarts at every slow tick. At each slow tick the length of the interval that just ended is latched as the scale, in fast cycles per slow tick.

When an event edge is detected, the block latches the slow count, the phase and the current scale together. A shift-add unit then forms slow_count × scale + phase. The result leaves on a valid/ready stream together with a flag that says whether a scale had been measured yet. The result stays on `ts_data` with `ts_valid` high until the consumer asserts `ts_ready`, so the consumer applies back-pressure by holding `ts_ready` low. While a result is being computed or is waiting to be taken, the block cannot accept another event. An event in that window is dropped and raises a sticky `overrun` flag.

Top module: `hr_timestamper`

## Requirements
- R1: Each `slow_tick` cycle increments the slow counter by exactly one and returns the phase counter to zero. In every other cycle the phase counter rises by one and the slow counter holds.
- R2: At each `slow_tick` the scale becomes the number of clock cycles since the previous tick, counting both ends' tick cycle once. For the first tick, the count runs from the release of reset. Before the first tick the scale is 0.
- R3: `event_in` goes through a two-flop synchroniser and a rising-edge detector. The capture takes place at the third rising clock edge at which `event_in` is sampled high. If a `slow_tick` falls on that same edge, the capture takes the slow count and the phase from before the tick and the scale from before the tick.
- R4: `ts_data` equals captured_slow × captured_scale + captured_phase, modulo 2^(SLOW_W+FAST_W).
- R5: `ts_calibrated` is 1 only if at least one `slow_tick` occurred before the capture edge. The internal calibrated state, once set, stays set until reset.
- R6: While `ts_valid` is high and `ts_ready` is low, `ts_valid` stays high and `ts_data` stays unchanged. A transfer happens on a clock edge where both are high, and `ts_valid` then falls.
- R7: `ts_valid` rises exactly FAST_W+1 cycles after the capture edge.
- R8: An event edge detected while a result is in progress or waiting, up to and including the accepting edge, is dropped and sets `overrun`. `overrun` stays set until reset.
- R9: After reset, `ts_valid` is 0 and `overrun` is 0.
- R10: An `event_in` held high for any length produces exactly one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock rising edge, already synchronised |
| event_in | input | 1 | Asynchronous event line; its rising edge is stamped |
| ts_valid | output | 1 | Timestamp available |
| ts_ready | input | 1 | Consumer accepts the timestamp |
| ts_data | output | SLOW_W+FAST_W | Timestamp in fast-clock periods |
| ts_calibrated | output | 1 | Scale had been measured when the event was captured |
| overrun | output | 1 | Sticky: an event was dropped |

## Verification
The bench sweeps every event phase within slow periods from 2 to 9 fast cycles. That sweep includes the case where the capture edge coincides with a slow tick. A design that took post-tick values in that case would return a value too large by one full period or would use a zero phase. Sampling the edge one cycle off would shift every stamp by one, and the latency check catches that as well. The bench also fires an event before any tick, holding the calibrated flag low, and stalls the consumer to show that the data stays stable. It fires a second event while the first is pending, which must be dropped and flagged. It holds the event line high for longer than the computation takes, and a level-sensitive capture would then return a second stamp.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    MA_IDLE,
    MA_RUN,
    MA_DONE,
    MA_HOLD
  } ma_state_t;
endpackage

// File: rtl/ts_event_sync.sv
module ts_event_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // one-cycle pulse on the first synchronised high sample
  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/ts_timebase.sv
module ts_timebase #(
  parameter int SLOW_W = 64,
  parameter int FAST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [SLOW_W-1:0] slow_cnt,
  output logic [FAST_W-1:0] fast_cnt,
  output logic [FAST_W-1:0] scale,
  output logic              calibrated
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_cnt   <= '0;
      fast_cnt   <= '0;
      scale      <= '0;
      calibrated <= 1'b0;
    end else if (tick) begin
      slow_cnt   <= slow_cnt + SLOW_W'(1);
      fast_cnt   <= '0;
      scale      <= fast_cnt + FAST_W'(1);
      calibrated <= 1'b1;
    end else begin
      fast_cnt   <= fast_cnt + FAST_W'(1);
    end
  end
endmodule

// File: rtl/ts_muladd.sv
module ts_muladd
  import ts_pkg::*;
#(
  parameter int SLOW_W = 64,
  parameter int FAST_W = 16,
  parameter int TS_W   = SLOW_W + FAST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOW_W-1:0] op_slow,
  input  logic [FAST_W-1:0] op_scale,
  input  logic [FAST_W-1:0] op_phase,
  input  logic              op_cal,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TS_W-1:0]   out_data,
  output logic              out_cal
);
  localparam int CNT_W = (FAST_W > 1) ? $clog2(FAST_W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(FAST_W - 1);

  ma_state_t         state_q;
  logic [TS_W-1:0]   acc_q;
  logic [TS_W-1:0]   mcand_q;
  logic [FAST_W-1:0] mplier_q;
  logic [CNT_W-1:0]  step_q;
  logic              cal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= MA_IDLE;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      step_q   <= '0;
      cal_q    <= 1'b0;
    end else begin
      unique case (state_q)
        MA_IDLE: if (start) begin
          acc_q    <= TS_W'(op_phase);
          mcand_q  <= TS_W'(op_slow);
          mplier_q <= op_scale;
          step_q   <= '0;
          cal_q    <= op_cal;
          state_q  <= MA_RUN;
        end
        MA_RUN: begin
          if (mplier_q[0]) acc_q <= acc_q + mcand_q;
          mcand_q  <= mcand_q << 1;
          mplier_q <= mplier_q >> 1;
          step_q   <= step_q + CNT_W'(1);
          if (step_q == LAST_STEP) state_q <= MA_DONE;
        end
        MA_DONE: state_q <= MA_HOLD;
        MA_HOLD: if (out_ready) state_q <= MA_IDLE;
        default: state_q <= MA_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != MA_IDLE);
  assign out_valid = (state_q == MA_HOLD);
  assign out_data  = acc_q;
  assign out_cal   = cal_q;
endmodule

// File: rtl/hr_timestamper.sv
module hr_timestamper #(
  parameter int SLOW_W      = 64,
  parameter int FAST_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int TS_W       = SLOW_W + FAST_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_tick,
  input  logic            event_in,
  output logic            ts_valid,
  input  logic            ts_ready,
  output logic [TS_W-1:0] ts_data,
  output logic            ts_calibrated,
  output logic            overrun
);
  logic [SLOW_W-1:0] slow_cnt;
  logic [FAST_W-1:0] fast_cnt;
  logic [FAST_W-1:0] scale;
  logic              calibrated;
  logic              ev_rise;
  logic              busy;
  logic              mul_start;
  logic              overrun_q;

  ts_event_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (event_in),
    .rise     (ev_rise)
  );

  ts_timebase #(.SLOW_W(SLOW_W), .FAST_W(FAST_W)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (slow_tick),
    .slow_cnt   (slow_cnt),
    .fast_cnt   (fast_cnt),
    .scale      (scale),
    .calibrated (calibrated)
  );

  assign mul_start = ev_rise & ~busy;

  // the operands are the counter values held before this edge
  ts_muladd #(.SLOW_W(SLOW_W), .FAST_W(FAST_W), .TS_W(TS_W)) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mul_start),
    .op_slow   (slow_cnt),
    .op_scale  (scale),
    .op_phase  (fast_cnt),
    .op_cal    (calibrated),
    .busy      (busy),
    .out_valid (ts_valid),
    .out_ready (ts_ready),
    .out_data  (ts_data),
    .out_cal   (ts_calibrated)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              overrun_q <= 1'b0;
    else if (ev_rise && busy) overrun_q <= 1'b1;
  end

  assign overrun = overrun_q;
endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
  parameter int SLOW_W = 64,
  parameter int FAST_W = 16,
  parameter int TS_W   = SLOW_W + FAST_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slow_tick,
  input logic              ev_rise,
  input logic              mul_start,
  input logic              busy,
  input logic              ts_valid,
  input logic              ts_ready,
  input logic [TS_W-1:0]   ts_data,
  input logic              overrun,
  input logic              calibrated,
  input logic [SLOW_W-1:0] slow_cnt,
  input logic [FAST_W-1:0] fast_cnt,
  input logic [FAST_W-1:0] scale
);
  logic [15:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        lat_q <= '0;
    else if (mul_start)                lat_q <= 16'd1;
    else if (lat_q != '0 && !ts_valid) lat_q <= lat_q + 16'd1;
  end

  p_slow_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> slow_cnt == $past(slow_cnt) + SLOW_W'(1));
  p_slow_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(slow_cnt));
  p_phase_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> fast_cnt == '0);
  p_scale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> scale == $past(fast_cnt) + FAST_W'(1));
  p_cal_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> calibrated);
  p_cal_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    calibrated |=> calibrated);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid && !ts_ready |=> ts_valid && $stable(ts_data));
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ts_valid) |-> lat_q == 16'(FAST_W + 2));
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise && busy |=> overrun);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> !ev_rise);
endmodule

bind hr_timestamper ts_checker #(.SLOW_W(SLOW_W), .FAST_W(FAST_W)) u_ts_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .slow_tick  (slow_tick),
  .ev_rise    (ev_rise),
  .mul_start  (mul_start),
  .busy       (busy),
  .ts_valid   (ts_valid),
  .ts_ready   (ts_ready),
  .ts_data    (ts_data),
  .overrun    (overrun),
  .calibrated (calibrated),
  .slow_cnt   (slow_cnt),
  .fast_cnt   (fast_cnt),
  .scale      (scale)
);

// File: tb/test_hr_timestamper.sv
module test_hr_timestamper;
  localparam int SW = 16;
  localparam int FW = 8;
  localparam int TW = SW + FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_tick = 1'b0;
  logic          event_in = 1'b0;
  logic          ts_ready = 1'b1;
  logic          ts_valid;
  logic [TW-1:0] ts_data;
  logic          ts_calibrated;
  logic          overrun;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hr_timestamper #(.SLOW_W(SW), .FAST_W(FW)) i_hr_timestamper (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .event_in(event_in),
    .ts_valid(ts_valid), .ts_ready(ts_ready), .ts_data(ts_data),
    .ts_calibrated(ts_calibrated), .overrun(overrun)
  );

  // expected time base, from R1/R2/R5
  logic [SW-1:0] m_slow;
  logic [FW-1:0] m_fast, m_h0;
  logic          m_cal;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slow <= '0; m_fast <= '0; m_h0 <= '0; m_cal <= 1'b0;
    end else if (slow_tick) begin
      m_slow <= m_slow + 1'b1; m_fast <= '0; m_h0 <= m_fast + 1'b1; m_cal <= 1'b1;
    end else begin
      m_fast <= m_fast + 1'b1;
    end
  end

  // slow tick generator, period in fast cycles
  bit tick_on = 0;
  int period = 4;
  int tcnt = 0;
  always @(negedge clk) begin
    if (!tick_on) begin
      slow_tick = 1'b0; tcnt = 0;
    end else if (tcnt >= period - 1) begin
      slow_tick = 1'b1; tcnt = 0;
    end else begin
      slow_tick = 1'b0; tcnt++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    tick_on = 0;
    event_in = 1'b0;
    ts_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // raise the event at a falling edge, hold it for hold_cyc falling edges,
  // stall the consumer for stall_cyc cycles, check value, flag and latency
  task automatic fire(input int hold_cyc, input int stall_cyc, input string tag);
    longint exp_v;
    bit     exp_c;
    int     waitc;
    logic [TW-1:0] first;
    if (stall_cyc > 0) ts_ready = 1'b0;
    @(negedge clk) event_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // values held just before the capture edge (R3)
    exp_v = (longint'(m_slow) * longint'(m_h0) + longint'(m_fast)) & ((64'd1 << TW) - 1);
    exp_c = m_cal;
    waitc = 0;
    while (!ts_valid && waitc < 100) begin
      @(negedge clk);
      waitc++;
      if (waitc + 2 >= hold_cyc) event_in = 1'b0;
    end
    check(waitc == FW + 2, {"R7 latency ", tag}, waitc, FW + 2);
    check(ts_data == TW'(exp_v), {"R4 value ", tag}, longint'(ts_data), exp_v);
    check(ts_calibrated == exp_c, {"R5 flag ", tag}, ts_calibrated, exp_c);
    first = ts_data;
    for (int i = 0; i < stall_cyc; i++) begin
      @(negedge clk);
      check(ts_valid && ts_data == first, {"R6 stall ", tag}, longint'(ts_data), longint'(first));
    end
    ts_ready = 1'b1;
    @(negedge clk);
    check(!ts_valid, {"R6 accept ", tag}, ts_valid, 0);
    while (event_in && waitc < hold_cyc) begin
      @(negedge clk);
      waitc++;
    end
    event_in = 1'b0;
  endtask

  initial begin
    do_reset();
    check(!ts_valid, "R9 valid after reset", ts_valid, 0);
    check(!overrun, "R9 overrun after reset", overrun, 0);

    // R5: event before any slow tick, scale 0, stamp equals phase
    repeat (5) @(negedge clk);
    fire(1, 0, "uncalibrated");

    // R1 R2 R3 R4: sweep every phase over several slow periods
    tick_on = 1;
    for (int p = 2; p <= 9; p++) begin
      period = p;
      repeat (2 * p + 2) @(negedge clk);
      for (int off = 0; off < p; off++) begin
        @(posedge clk iff slow_tick);
        repeat (off) @(negedge clk);
        fire(1, 0, $sformatf("R1 R2 R3 sweep p=%0d off=%0d", p, off));
      end
    end

    // R6: consumer stall
    period = 5;
    repeat (12) @(negedge clk);
    fire(1, 7, "backpressure");

    // R10: level held long past completion yields one result
    fire(40, 0, "held level");
    repeat (20) @(negedge clk);
    check(!ts_valid, "R10 no second result", ts_valid, 0);
    check(!overrun, "R10 no overrun from level", overrun, 0);

    // R8: second edge while the first result waits
    begin
      ts_ready = 1'b0;
      @(negedge clk) event_in = 1'b1;
      repeat (4) @(negedge clk);
      event_in = 1'b0;
      repeat (4) @(negedge clk);
      event_in = 1'b1;
      repeat (4) @(negedge clk);
      event_in = 1'b0;
      repeat (FW + 4) @(negedge clk);
      check(overrun, "R8 overrun set", overrun, 1);
      check(ts_valid, "R8 first result kept", ts_valid, 1);
      ts_ready = 1'b1;
      @(negedge clk);
      repeat (FW + 8) @(negedge clk);
      check(!ts_valid, "R8 second event dropped", ts_valid, 0);
      check(overrun, "R8 overrun sticky", overrun, 1);
    end

    do_reset();
    check(!overrun, "R9 overrun cleared by reset", overrun, 0);
    check(!ts_valid, "R9 valid cleared by reset", ts_valid, 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule